// File: doc/BRIEF.md
# Touch ADC serial conversion sequencer

This block is the digital heart of a four-wire resistive touch-panel converter seen from the host side of a three-wire serial link. It waits for a start bit, collects a seven-bit control word, powers the selected panel axis while the input is sampled, runs the successive-approximation steps on the serial clock, and returns the result most significant bit first with zero padding behind it. It also derives the enables for the X and Y panel drivers, the pen-detect interrupt and the Y- pull-down switch used while the converter is idle.

The serial pins (`cs_n`, `dclk`, `din`) are sampled by a fast system clock, and all events are taken from the detected edges of `dclk`. The comparator outcome is replaced by a behavioural port, `cmp_code`, which carries the code the converter would find; it is captured at the moment the input goes into hold. Output enables stand in for the high-impedance pins.

Top module: `tsc_seq`

## Requirements
- R1: While `cs_n` is low, `din` is sampled on each `dclk` rising edge; low bits are skipped until a high start bit, and the next seven rising edges carry, in this order, channel bits C2 C1 C0, length bit (1 = 8-bit), reference bit (1 = single-ended, 0 = ratiometric), power bits P1 P0.
- R2: `busy` goes high at the `dclk` falling edge that follows the seventh word bit and returns low at the next falling edge; `dout` is low while `busy` is high.
- R3: From the falling edge after `busy` rises, `dout` presents the code captured from `cmp_code` at the hold edge, MSB first in straight binary, one bit per falling edge: all 12 bits when the length bit is 0, the upper 8 bits when it is 1.
- R4: After the last result bit, and whenever no result bit is pending, `dout` is driven low.
- R5: A new start bit is accepted no earlier than the 15th rising edge after the previous start for a 12-bit word and the 11th for an 8-bit word; high `din` bits before that are ignored and the running readout continues undisturbed.
- R6: Channel 001 enables only `y_drv_en`, channel 101 enables only `x_drv_en`; every other channel code enables neither.
- R7: The selected drivers turn on at the rising edge that delivers the reference bit and stay on until the hold edge; in ratiometric mode they stay on until the last result bit has been presented.
- R8: Outside acquisition and conversion, power bits 00 raise `penirq_en` and `yneg_drv_en`; 01 and 10 keep both low; 11 keeps both low and leaves the last word's drivers on until the next acquisition.
- R9: With `cs_n` high, `dout_oe` and `busy_oe` are low, and raising `cs_n` at any point aborts the word or conversion, clears `busy` and `dout`, and reopens start-bit search.
- R10: After reset, `dout`, `busy`, both output enables and both axis drivers are low, while `penirq_en` and `yneg_drv_en` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| dclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| cmp_code | input | RES | Behavioural comparator target code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` |
| busy | output | 1 | Conversion in hold, result not yet shown |
| busy_oe | output | 1 | Drive enable for `busy` |
| penirq_en | output | 1 | Pen-detect interrupt enabled |
| x_drv_en | output | 1 | X panel drivers on |
| y_drv_en | output | 1 | Y panel drivers on |
| yneg_drv_en | output | 1 | Y- pull-down switch on while idle |

## Verification
The readout of one result and the reception of the next control word share the same `dclk` edges when words are spaced at the minimum 15 or 11 clocks. The bench provokes this by sending the follow-on word right after the ignore window, with high `din` bits filling that window, and a behavioural model with a result queue predicts `dout`, `busy` and every enable at each `dclk` half-period. The result must stream out intact while the new word is collected, and the early high bits must start nothing.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // Control word as collected after the start bit, first received bit on top.
  typedef struct packed {
    logic [2:0] chan;
    logic       short_mode;
    logic       single_ended;
    logic [1:0] pd;
  } tsc_cfg_t;

  localparam logic [2:0] CH_Y_AXIS = 3'b001;
  localparam logic [2:0] CH_X_AXIS = 3'b101;
  localparam logic [1:0] PD_AUTO   = 2'b00;
  localparam logic [1:0] PD_FULL   = 2'b11;
endpackage

// File: rtl/tsc_rx.sv
module tsc_rx
  import tsc_pkg::*;
#(
  parameter int RES       = 12,
  parameter int SHORT_RES = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     abort,
  input  logic     rise,
  input  logic     fall,
  input  logic     din,
  output logic     byte_rdy,
  output tsc_cfg_t cfg,
  output logic     acq_on,
  output logic [2:0] acq_chan
);
  localparam int GW = $clog2(RES + 4);
  localparam logic [GW-1:0] GAP_MAX = '1;
  localparam logic [GW-1:0] SPAN_L  = GW'(RES + 3);
  localparam logic [GW-1:0] SPAN_S  = GW'(SHORT_RES + 3);

  logic          active;
  logic [2:0]    idx;
  logic [6:0]    sh;
  logic [GW-1:0] gap;
  logic          last_short;
  logic [GW-1:0] span;
  logic [GW-1:0] gap_inc;

  assign span    = last_short ? SPAN_S : SPAN_L;
  assign gap_inc = (gap == GAP_MAX) ? gap : gap + GW'(1);
  assign cfg     = tsc_cfg_t'(sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      idx        <= '0;
      sh         <= '0;
      gap        <= GAP_MAX;
      last_short <= 1'b0;
      byte_rdy   <= 1'b0;
      acq_on     <= 1'b0;
      acq_chan   <= '0;
    end else if (abort) begin
      active   <= 1'b0;
      idx      <= '0;
      gap      <= GAP_MAX;
      byte_rdy <= 1'b0;
      acq_on   <= 1'b0;
    end else begin
      if (fall && byte_rdy) begin
        byte_rdy <= 1'b0;
        acq_on   <= 1'b0;
      end
      if (rise) begin
        if (active) begin
          sh  <= {sh[5:0], din};
          gap <= gap_inc;
          if (idx == 3'd5) begin
            acq_on   <= 1'b1;
            acq_chan <= sh[3:1];
          end
          if (idx == 3'd7) begin
            byte_rdy   <= 1'b1;
            active     <= 1'b0;
            last_short <= sh[2];
          end else begin
            idx <= idx + 3'd1;
          end
        end else if (din && (gap >= span)) begin
          active <= 1'b1;
          idx    <= 3'd1;
          gap    <= GW'(1);
        end else begin
          gap <= gap_inc;
        end
      end
    end
  end
endmodule

// File: rtl/tsc_conv.sv
module tsc_conv
  import tsc_pkg::*;
#(
  parameter int RES       = 12,
  parameter int SHORT_RES = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           abort,
  input  logic           launch,
  input  logic           fall,
  input  tsc_cfg_t       cfg_in,
  input  logic [RES-1:0] code,
  output logic           dout,
  output logic           busy,
  output logic           active,
  output tsc_cfg_t       cfg_q,
  output logic           cfg_valid
);
  localparam int CW = $clog2(RES);
  localparam logic [CW-1:0] LAST_L = CW'(RES - 1);
  localparam logic [CW-1:0] LAST_S = CW'(SHORT_RES - 1);

  logic [RES-1:0] sh;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  last;

  assign last = cfg_q.short_mode ? LAST_S : LAST_L;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      cnt       <= '0;
      dout      <= 1'b0;
      busy      <= 1'b0;
      active    <= 1'b0;
      cfg_q     <= '{chan: 3'b000, short_mode: 1'b0, single_ended: 1'b1, pd: PD_AUTO};
      cfg_valid <= 1'b0;
    end else if (abort) begin
      dout   <= 1'b0;
      busy   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else if (launch) begin
      cfg_q     <= cfg_in;
      cfg_valid <= 1'b1;
      sh        <= code;
      busy      <= 1'b1;
      dout      <= 1'b0;
      active    <= 1'b1;
      cnt       <= '0;
    end else if (fall) begin
      if (active) begin
        busy <= 1'b0;
        dout <= sh[RES-1];
        sh   <= {sh[RES-2:0], 1'b0};
        cnt  <= cnt + CW'(1);
        if (cnt == last) active <= 1'b0;
      end else begin
        dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsc_drv.sv
module tsc_drv
  import tsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     acq_on,
  input  logic [2:0] acq_chan,
  input  logic     conv_active,
  input  tsc_cfg_t cfg_q,
  input  logic     cfg_valid,
  output logic     x_en,
  output logic     y_en,
  output logic     pen_en,
  output logic     yneg_en
);
  logic       idle;
  logic       on;
  logic [2:0] chan;
  logic [1:0] pd_eff;

  always_comb begin
    idle   = !acq_on && !conv_active;
    chan   = acq_on ? acq_chan : cfg_q.chan;
    pd_eff = cfg_valid ? cfg_q.pd : PD_AUTO;
    on     = acq_on
          || (cfg_valid && conv_active && !cfg_q.single_ended)
          || (cfg_valid && !acq_on && (pd_eff == PD_FULL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_en    <= 1'b0;
      y_en    <= 1'b0;
      pen_en  <= 1'b1;
      yneg_en <= 1'b1;
    end else begin
      x_en    <= on && (chan == CH_X_AXIS);
      y_en    <= on && (chan == CH_Y_AXIS);
      pen_en  <= idle && (pd_eff == PD_AUTO);
      yneg_en <= idle && (pd_eff == PD_AUTO);
    end
  end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
  import tsc_pkg::*;
#(
  parameter int RES       = 12,
  parameter int SHORT_RES = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           dclk,
  input  logic           din,
  input  logic [RES-1:0] cmp_code,
  output logic           dout,
  output logic           dout_oe,
  output logic           busy,
  output logic           busy_oe,
  output logic           penirq_en,
  output logic           x_drv_en,
  output logic           y_drv_en,
  output logic           yneg_drv_en
);
  logic       dclk_q;
  logic       rise_evt;
  logic       fall_evt;
  logic       byte_rdy;
  logic       launch;
  logic       acq_on;
  logic [2:0] acq_chan;
  logic       conv_active;
  logic       cfg_valid;
  tsc_cfg_t   rx_cfg;
  tsc_cfg_t   cur_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_q  <= 1'b0;
      dout_oe <= 1'b0;
      busy_oe <= 1'b0;
    end else begin
      dclk_q  <= dclk;
      dout_oe <= !cs_n;
      busy_oe <= !cs_n;
    end
  end

  assign rise_evt = !cs_n && dclk && !dclk_q;
  assign fall_evt = !cs_n && !dclk && dclk_q;
  assign launch   = fall_evt && byte_rdy;

  tsc_rx #(.RES(RES), .SHORT_RES(SHORT_RES)) u_rx (
    .clk(clk), .rst(rst), .abort(cs_n), .rise(rise_evt), .fall(fall_evt),
    .din(din), .byte_rdy(byte_rdy), .cfg(rx_cfg), .acq_on(acq_on),
    .acq_chan(acq_chan)
  );

  tsc_conv #(.RES(RES), .SHORT_RES(SHORT_RES)) u_conv (
    .clk(clk), .rst(rst), .abort(cs_n), .launch(launch), .fall(fall_evt),
    .cfg_in(rx_cfg), .code(cmp_code), .dout(dout), .busy(busy),
    .active(conv_active), .cfg_q(cur_cfg), .cfg_valid(cfg_valid)
  );

  tsc_drv u_drv (
    .clk(clk), .rst(rst), .acq_on(acq_on), .acq_chan(acq_chan),
    .conv_active(conv_active), .cfg_q(cur_cfg), .cfg_valid(cfg_valid),
    .x_en(x_drv_en), .y_en(y_drv_en), .pen_en(penirq_en),
    .yneg_en(yneg_drv_en)
  );
endmodule

// File: rtl/tsc_seq_chk.sv
module tsc_seq_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic fall_evt,
  input logic dout,
  input logic dout_oe,
  input logic busy,
  input logic busy_oe,
  input logic penirq_en,
  input logic x_drv_en,
  input logic y_drv_en
);
  assert_busy_low_dout_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dout);

  assert_busy_one_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && fall_evt) |=> !busy);

  assert_axis_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(x_drv_en && y_drv_en));

  assert_pen_drivers_off_R8: assert property (@(posedge clk) disable iff (rst)
    penirq_en |-> (!x_drv_en && !y_drv_en));

  assert_deselect_oe_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout_oe && !busy_oe));

  assert_deselect_clear_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout && !busy));
endmodule

bind tsc_seq tsc_seq_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .fall_evt(fall_evt), .dout(dout),
  .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe), .penirq_en(penirq_en),
  .x_drv_en(x_drv_en), .y_drv_en(y_drv_en)
);

// File: tb/tsc_seq_tb.sv
module tsc_seq_tb;
  localparam int RES  = 12;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst, cs_n, dclk, din;
  logic [RES-1:0] cmp_code;
  logic dout, dout_oe, busy, busy_oe, penirq_en, x_drv_en, y_drv_en, yneg_drv_en;

  always #5 clk = ~clk;

  tsc_seq #(.RES(RES), .SHORT_RES(8)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .dclk(dclk), .din(din),
    .cmp_code(cmp_code), .dout(dout), .dout_oe(dout_oe), .busy(busy),
    .busy_oe(busy_oe), .penirq_en(penirq_en), .x_drv_en(x_drv_en),
    .y_drv_en(y_drv_en), .yneg_drv_en(yneg_drv_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] cap = '0;

  // behavioural reference model state
  int   m_rx = -1;
  int   m_gap = 99;
  int   m_span = 15;
  bit [6:0] m_sh = '0;
  bit   m_rdy = 0, m_acq = 0, m_conv = 0, m_busy = 0, m_dout = 0, m_valid = 0;
  bit [2:0] m_acq_ch = 0, m_ch = 0;
  bit   m_se = 1;
  bit [1:0] m_pd = 0;
  bit   m_bits[$];

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_rise(input bit d);
    if (m_rx > 0) begin
      m_sh = {m_sh[5:0], d};
      m_gap++;
      if (m_rx == 5) begin m_acq = 1; m_acq_ch = m_sh[4:2]; end
      if (m_rx == 7) begin
        m_rdy = 1; m_rx = -1;
        m_span = m_sh[3] ? 11 : 15;
      end else m_rx++;
    end else if (d && m_gap >= m_span) begin
      m_rx = 1; m_gap = 1;
    end else m_gap++;
  endtask

  task automatic m_fall();
    if (m_rdy) begin
      int nb;
      m_rdy = 0; m_acq = 0;
      m_ch = m_sh[6:4]; m_se = m_sh[2]; m_pd = m_sh[1:0]; m_valid = 1;
      nb = m_sh[3] ? 8 : 12;
      m_bits.delete();
      for (int i = 0; i < nb; i++) m_bits.push_back(cmp_code[RES-1-i]);
      m_busy = 1; m_dout = 0; m_conv = 1;
    end else if (m_conv) begin
      m_busy = 0;
      m_dout = m_bits.pop_front();
      if (m_bits.size() == 0) m_conv = 0;
    end else m_dout = 0;
  endtask

  task automatic m_abort();
    m_rx = -1; m_gap = 99; m_rdy = 0; m_acq = 0; m_conv = 0;
    m_bits.delete(); m_busy = 0; m_dout = 0;
  endtask

  task automatic compare_all();
    bit idle, on, ex, ey, pen;
    bit [2:0] ch;
    bit [1:0] pdeff;
    idle  = !m_acq && !m_conv;
    ch    = m_acq ? m_acq_ch : m_ch;
    pdeff = m_valid ? m_pd : 2'b00;
    on    = m_acq || (m_valid && m_conv && !m_se) || (m_valid && !m_acq && m_pd == 2'b11);
    ey    = on && ch == 3'b001;
    ex    = on && ch == 3'b101;
    pen   = idle && pdeff == 2'b00;
    chk("R3 R4 dout", dout, m_dout);
    chk("R2 busy", busy, m_busy);
    chk("R9 dout_oe", dout_oe, !cs_n);
    chk("R9 busy_oe", busy_oe, !cs_n);
    chk("R6 R7 x_drv_en", x_drv_en, ex);
    chk("R6 R7 y_drv_en", y_drv_en, ey);
    chk("R8 penirq_en", penirq_en, pen);
    chk("R8 yneg_drv_en", yneg_drv_en, pen);
  endtask

  task automatic half(input logic lvl, input logic d);
    logic prev;
    @(negedge clk);
    prev = dclk;
    din  = d;
    dclk = lvl;
    if (!cs_n && prev !== lvl) begin
      if (lvl) m_rise(d); else m_fall();
    end
    repeat (HALF - 1) @(negedge clk);
    compare_all();
  endtask

  task automatic bit_clk(input logic d);
    half(1'b0, d);
    cap = {cap[14:0], dout};
    half(1'b1, d);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) bit_clk(w[i]);
  endtask

  task automatic fill(input int n, input logic d);
    for (int i = 0; i < n; i++) bit_clk(d);
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk);
    cs_n = v;
    dclk = 1'b0;
    if (v) m_abort();
    repeat (HALF - 1) @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; dclk = 1'b0; din = 1'b0; cmp_code = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dout", dout, 1'b0);
    chk("R10 busy", busy, 1'b0);
    chk("R10 dout_oe", dout_oe, 1'b0);
    chk("R10 busy_oe", busy_oe, 1'b0);
    chk("R10 x_drv_en", x_drv_en, 1'b0);
    chk("R10 y_drv_en", y_drv_en, 1'b0);
    chk("R10 penirq_en", penirq_en, 1'b1);
    chk("R10 yneg_drv_en", yneg_drv_en, 1'b1);

    // R1: leading low bits ignored, 12-bit single-ended Y axis, PD 00
    cmp_code = 12'hA5C;
    set_cs(1'b0);
    fill(3, 1'b0);
    chk("R1 leading zeros start nothing", busy, 1'b0);
    send_word(8'b1_001_0_1_00);
    fill(16, 1'b0);
    chk_vec("R3 12-bit result", {4'h0, cap[14:3]}, {4'h0, 12'hA5C});

    // R3 8-bit ratiometric X axis, PD 01
    cmp_code = 12'h3C7;
    send_word(8'b1_101_1_0_01);
    fill(12, 1'b0);
    chk_vec("R3 8-bit result", {8'h00, cap[10:3]}, 16'h003C);

    // R5: 15-clock spacing, high bits in the ignore window
    cmp_code = 12'h7E1;
    send_word(8'b1_001_0_0_11);
    fill(7, 1'b1);
    cmp_code = 12'h19B;
    send_word(8'b1_010_0_1_11);
    chk_vec("R5 readout kept during overlapped word", {4'h0, cap[13:2]}, {4'h0, 12'h7E1});
    fill(16, 1'b0);
    chk_vec("R6 channel 010 result", {4'h0, cap[14:3]}, {4'h0, 12'h19B});

    // R8: PD 11 keeps the X drivers on when idle
    cmp_code = 12'h0F0;
    send_word(8'b1_101_0_1_11);
    fill(16, 1'b0);
    chk("R8 full-power drivers held", x_drv_en, 1'b1);

    // R5: 11-clock spacing in 8-bit mode
    cmp_code = 12'hC3A;
    send_word(8'b1_001_1_1_00);
    fill(3, 1'b1);
    send_word(8'b1_101_1_1_00);
    chk_vec("R5 8-bit readout kept", {8'h00, cap[9:2]}, 16'h00C3);
    fill(12, 1'b0);

    // R9: abort in mid conversion, then a clean frame
    cmp_code = 12'hFFF;
    send_word(8'b1_101_0_0_00);
    fill(5, 1'b0);
    set_cs(1'b1);
    chk("R9 abort clears busy", busy, 1'b0);
    set_cs(1'b0);
    fill(2, 1'b0);
    chk("R9 no resumed readout", dout, 1'b0);
    cmp_code = 12'h555;
    send_word(8'b1_001_0_1_00);
    fill(16, 1'b0);
    chk_vec("R9 frame after abort", {4'h0, cap[14:3]}, {4'h0, 12'h555});
    set_cs(1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule